// File: doc/BRIEF.md
# Latched Interrupt Status and Mask Controller

The block gathers interrupt requests from up to 32 peripheral sources into a 32-bit status register. A request pulse on one line of `irq_req` latches the bit with the same index. The bit then stays set until software clears it. A 32-bit mask register selects which latched bits may reach the processor. The processor interrupt line `cpu_irq` is high whenever at least one latched bit has its mask bit set. The request from the DMA interrupt logic is expected on line 3.

Software reaches both registers over a simple register bus. The bus has an address, a write strobe, write data, a half-width qualifier and combinational read data. A status write works as an acknowledge: the written word is ANDed into the status, so only bits written as 0 are cleared. Bits named in the `STICKY_SRCS` parameter model sources that are held active by configuration. Software cannot clear them. A mask write replaces the mask, and pending requests are evaluated against the new mask straight away. When the half-width qualifier is set, an access touches only the low 16 bits of a register.

A two-state controller sequences reset. `ST_SEED` is held during reset and lasts for the first clock after it. In that state the status is loaded with the sticky bits and bus writes are ignored. The transition `SEED_DONE` then moves to `ST_RUN` and stays there until the next reset. All normal operation happens in `ST_RUN`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: During reset and directly after it, the register at offset 0x74 (the mask) reads 0 and `cpu_irq` is 0. From the second clock after reset is released, the register at offset 0x70 (the status) reads exactly the sticky bits, which are bit 7 and bit 9 (0x0000_0280) by default.
- R2: A one-cycle high pulse on `irq_req[i]` sets status bit i, and the bit stays set after the pulse ends.
- R3: A full-width write to offset 0x70 clears each status bit whose written bit is 0. Each status bit whose written bit is 1 keeps its value.
- R4: Sticky status bits read 1 after any status write, including a write of all zeros.
- R5: When a request pulse on line i arrives in the same cycle as a status write that has bit i at 0, status bit i ends up set.
- R6: A full-width write to offset 0x74 replaces the whole mask, and the new value reads back.
- R7: `cpu_irq` is a register holding the OR of (status AND mask). It follows any change of status or mask one clock later.
- R8: A mask write that unmasks an already pending status bit raises `cpu_irq` on the second clock edge after the write, with no new request needed.
- R9: With `bus_half`=1, a write changes only bits 15:0. A status write leaves status bits 31:16 untouched. A mask write keeps mask bits 31:16.
- R10: With `bus_half`=1, a read returns bits 15:0 of the register with bits 31:16 as zero. Any address other than 0x70 and 0x74 reads 0, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | 32 | Request pulses, one per source |
| cpu_irq | output | 1 | Registered interrupt line to the processor |

## Verification
The status path is tested with several patterns. Single and multiple request pulses show that bits latch. Acknowledge words with mixed ones and zeros show that the AND keeps the bits written as 1. An all-zeros acknowledge separates sticky bits from ordinary ones. A request that coincides with a clearing write tests which of the two takes priority. The interrupt line is sampled one and two edges after a mask write that uncovers a pending bit, which pins down the single-register latency. Half-width writes and reads, together with a write to an unmapped offset, show that the upper halves and the two registers stay intact.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] STICKY = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              run,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] keep_bits,
    input  logic [DATA_W-1:0] req,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] status_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (seed) begin
                status_q[i] <= STICKY[i] | req[i];
            end else if (wr_en) begin
                status_q[i] <= (status_q[i] & keep_bits[i]) | STICKY[i] | req[i];
            end else begin
                status_q[i] <= status_q[i] | req[i];
            end
        end
    end

    assign status = status_q;

    // R2
    req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (|req)) |=> ((status_q & $past(req)) == $past(req)));

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en) |=> ((status_q & ~$past(keep_bits) & ~$past(req) & ~STICKY) == '0));

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((status_q & STICKY) == STICKY));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              half,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= half ? {mask_q[DATA_W-1:HALF_W], wdata[HALF_W-1:0]} : wdata;
        end
    end

    assign mask = mask_q;

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !half) |=> (mask_q == $past(wdata)));

    // R9
    mask_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && half) |=> (mask_q[DATA_W-1:HALF_W] == $past(mask_q[DATA_W-1:HALF_W])));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74,
    parameter logic [DATA_W-1:0] STICKY_SRCS = 32'h0000_0280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] irq_req,
    output logic              cpu_irq
);
    import irq_latch_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    irq_state_e state_q, state_d;
    logic seed, run;
    logic hit_stat, hit_mask;
    logic wr_stat, wr_mask;
    logic [DATA_W-1:0] keep_bits;
    logic [DATA_W-1:0] status, mask;
    logic [DATA_W-1:0] rd_full;
    logic irq_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and state outputs
    always_comb begin
        state_d = state_q;
        seed    = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            ST_SEED: begin
                seed    = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                run = 1'b1;
            end
        endcase
    end

    assign hit_stat = (bus_addr == STAT_OFS);
    assign hit_mask = (bus_addr == MASK_OFS);
    assign wr_stat  = run && bus_wr && hit_stat;
    assign wr_mask  = run && bus_wr && hit_mask;

    // A half-width acknowledge treats the upper half as written with ones.
    assign keep_bits = bus_half ? {{HALF_W{1'b1}}, bus_wdata[HALF_W-1:0]} : bus_wdata;

    irq_status_reg #(
        .DATA_W (DATA_W),
        .STICKY (STICKY_SRCS)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed      (seed),
        .run       (run),
        .wr_en     (wr_stat),
        .keep_bits (keep_bits),
        .req       (irq_req),
        .status    (status)
    );

    irq_mask_reg #(
        .DATA_W (DATA_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_mask),
        .half  (bus_half),
        .wdata (bus_wdata),
        .mask  (mask)
    );

    always_comb begin
        rd_full = '0;
        if (hit_stat) rd_full = status;
        else if (hit_mask) rd_full = mask;
    end

    assign bus_rdata = bus_half ? {{HALF_W{1'b0}}, rd_full[HALF_W-1:0]} : rd_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & mask);
        end
    end

    assign cpu_irq = irq_q;

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(|(status & mask)));

    // R8
    unmask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !bus_half && (|(status & bus_wdata))) |=> ##1 cpu_irq);

    // R1
    seed_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
endmodule

// File: tb/irq_latch_ctrl_test.sv
`timescale 1ns/1ps
module irq_latch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_req = '0;
    logic        cpu_irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [7:0] A_ST = 8'h70;
    localparam logic [7:0] A_MK = 8'h74;
    localparam logic [31:0] STK = 32'h0000_0280;

    always #2.5 clk = ~clk;

    irq_latch_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_half  (bus_half),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a write for one cycle; registers change at the next posedge.
    task automatic bus_write(logic [7:0] a, logic [31:0] d, logic h, logic [31:0] rq);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_half  = h;
        bus_wr    = 1'b1;
        irq_req   = rq;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_half  = 1'b0;
        irq_req   = '0;
    endtask

    task automatic bus_read(logic [7:0] a, logic h, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_half = h;
        #1;
        d = bus_rdata;
        bus_half = 1'b0;
    endtask

    task automatic pulse(logic [31:0] rq);
        @(negedge clk);
        irq_req = rq;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(A_MK, 1'b0, v);
        check("R1 mask after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        bus_read(A_ST, 1'b0, v);
        check("R1 status seeded", v, STK);
    endtask

    task automatic t_request;
        logic [31:0] v;
        pulse(32'h0010_0008);
        repeat (2) @(negedge clk);
        bus_read(A_ST, 1'b0, v);
        check("R2 latched requests", v, STK | 32'h0010_0008);
        check("R7 masked irq low", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        bus_write(A_ST, 32'hFFFF_FFF7, 1'b0, '0);
        bus_read(A_ST, 1'b0, v);
        check("R3 and-clear", v, STK | 32'h0010_0000);
        bus_write(A_ST, 32'h0, 1'b0, '0);
        bus_read(A_ST, 1'b0, v);
        check("R4 sticky survives zero write", v, STK);
    endtask

    task automatic t_race;
        logic [31:0] v;
        bus_write(A_ST, 32'h0, 1'b0, 32'h0000_0020);
        bus_read(A_ST, 1'b0, v);
        check("R5 request wins over clear", v, STK | 32'h20);
    endtask

    task automatic t_unmask;
        logic [31:0] v;
        bus_write(A_MK, 32'h0000_0020, 1'b0, '0);
        // write edge passed; irq register still reflects the old mask
        check("R7 irq one edge after mask write", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R8 irq raised by mask write", {31'b0, cpu_irq}, 32'h1);
        bus_read(A_MK, 1'b0, v);
        check("R6 mask readback", v, 32'h20);
        bus_write(A_ST, 32'hFFFF_FFDF, 1'b0, '0);
        check("R7 irq holds one edge after clear", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk);
        check("R7 irq drops after clear", {31'b0, cpu_irq}, 32'h0);
        bus_write(A_MK, 32'h0000_0080, 1'b0, '0);
        @(negedge clk);
        check("R4 sticky bit drives irq", {31'b0, cpu_irq}, 32'h1);
        bus_write(A_MK, 32'h0, 1'b0, '0);
        @(negedge clk);
        check("R7 irq low with mask zero", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_half;
        logic [31:0] v;
        pulse(32'h0010_0008);
        bus_write(A_ST, 32'h0000_0000, 1'b1, '0);
        bus_read(A_ST, 1'b0, v);
        check("R9 half ack keeps upper status", v, STK | 32'h0010_0000);
        bus_write(A_MK, 32'hABCD_0000, 1'b0, '0);
        bus_write(A_MK, 32'h5555_1234, 1'b1, '0);
        bus_read(A_MK, 1'b0, v);
        check("R9 half mask write keeps upper", v, 32'hABCD_1234);
        bus_read(A_MK, 1'b1, v);
        check("R10 half read zero-extends", v, 32'h0000_1234);
        bus_write(8'h78, 32'hFFFF_FFFF, 1'b0, '0);
        bus_read(8'h78, 1'b0, v);
        check("R10 unmapped reads zero", v, 32'h0);
        bus_read(A_MK, 1'b0, v);
        check("R10 unmapped write leaves mask", v, 32'hABCD_1234);
        bus_read(A_ST, 1'b0, v);
        check("R10 unmapped write leaves status", v, STK | 32'h0010_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, cpu_irq}, 32'h0);
        rst_n = 1'b1;
        t_reset();
        t_request();
        t_ack();
        t_race();
        t_unmask();
        t_half();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule